// File: doc/BRIEF.md
# Prescaled Match Timer with Latched Interrupt Flags

This block is a peripheral timer that is set up and observed through a simple synchronous register port. A prescale counter divides the clock. Each time it wraps, the main timer counter advances by one. Four compare channels watch the timer counter. Each channel has its own control bits, and these decide independently whether a compare hit latches an interrupt flag, returns the counter to zero, or halts the timer.

Latched flags drive a level interrupt request. That request stays high until software writes a one to the matching flag bit. Writing a zero leaves the flag alone. When a new compare hit arrives in the same cycle as the clearing write, the hit wins. A handler that clears its flag late therefore cannot lose an event. It will instead see the request still high, which is the correct result.

Reads have one cycle of latency: the read data is registered from the address presented on the previous edge. Writes take effect on the clock edge at which `reg_we` is sampled high.

Top module: `match_timer`

## Requirements
- R1: A synchronous active-high reset clears the run bit, prescale limit, prescale count, timer count, all match values, all channel control bits and all flags, and drives `irq` and `reg_rdata` low.
- R2: While the run bit (bit 0 of address 0x0) is one, the timer count (address 0x3) advances by one once every PRESCALE+1 clock cycles, where PRESCALE is the value at address 0x1. While the run bit is zero, neither the prescale count (address 0x2) nor the timer count changes.
- R3: When a channel's reset bit is set and the timer count equals that channel's match value on an advance, the count becomes zero instead of incrementing. This gives a period of match+1 advances. The reset bit of channel k is bit 3k+1 of address 0x4.
- R4: When no hitting channel has its reset bit set, the timer count increments past the match value.
- R5: When a channel's interrupt bit is set, a hit latches flag bit k at address 0x5. The interrupt bit of channel k is bit 3k of address 0x4. With the interrupt bit clear, a hit latches nothing.
- R6: Writing a one to bit k of address 0x5 clears flag k. Writing a zero to a bit leaves that flag unchanged.
- R7: When a hit sets flag k in the same cycle as a write that clears flag k, the flag ends up set.
- R8: `irq` is a registered level. It is high exactly when at least one flag is set, and it stays high until every set flag has been cleared.
- R9: When a channel's stop bit is set, a hit clears the run bit, and the counters then hold their values. The stop bit of channel k is bit 3k+2 of address 0x4. If the hit coincides with a software write to the run bit, the stop takes priority.
- R10: The read port returns, one cycle after the address is presented, the register at that address. Match value k is at address 0x8+k. Unused addresses read as zero. Writes to addresses 0x2 and 0x3 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Register address for both read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data for the address presented on the previous edge |
| irq | output | 1 | Level interrupt request, high while any flag is set |

## Verification
Two pairs of events can fall in the same cycle. A compare hit can coincide with the software write that clears its flag, and a stop hit can coincide with a write to the run bit. The bench provokes the first pair by counting the exact edge on which a periodic channel hits again, then issuing the clearing write on that same edge. It judges the outcome by reading the flag back afterwards: a cleared flag would mean the event was lost. The interrupt level is sampled at points chosen to separate set, held and cleared states, and the counter is read at cycle-exact points to confirm the period of the prescaler and the reset-on-match behaviour.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'h0;
  localparam logic [ADDR_W-1:0] A_PRESC  = 4'h1;
  localparam logic [ADDR_W-1:0] A_PCNT   = 4'h2;
  localparam logic [ADDR_W-1:0] A_COUNT  = 4'h3;
  localparam logic [ADDR_W-1:0] A_MCTRL  = 4'h4;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 4'h5;
  localparam logic [ADDR_W-1:0] A_MATCH0 = 4'h8;

  localparam int MC_BITS = 3;
  localparam int MC_IRQ  = 0;
  localparam int MC_CLR  = 1;
  localparam int MC_STOP = 2;

  localparam int RUN_BIT = 0;
endpackage

// File: rtl/mt_prescale.sv
module mt_prescale #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic [W-1:0] pcount,
  output logic         tick
);
  // a wrap occurs on reaching (or passing) the limit, so lowering the
  // limit mid-count never leaves the counter stuck above it
  assign tick = run && (pcount >= limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcount <= '0;
    end else if (run) begin
      if (tick) pcount <= '0;
      else      pcount <= pcount + 1'b1;
    end
  end

  // R2: prescale count frozen while the timer is halted
  p_pc_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(pcount));
endmodule

// File: rtl/mt_count.sv
module mt_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clr_hit,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (tick) begin
      if (clr_hit) count <= '0;
      else         count <= count + 1'b1;
    end
  end

  // R3: reset-on-match returns the count to zero
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && clr_hit) |=> (count == '0));

  // R2: no advance without a prescale wrap
  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count));
endmodule

// File: rtl/mt_match_bank.sv
module mt_match_bank
  import mt_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 32
) (
  input  logic                 tick,
  input  logic [W-1:0]         count,
  input  logic [N-1:0][W-1:0]  match_vals,
  input  logic [N*MC_BITS-1:0] mctrl,
  output logic [N-1:0]         flag_set,
  output logic                 clr_hit,
  output logic                 stop_hit
);
  logic [N-1:0] hit;
  logic [N-1:0] clr_vec;
  logic [N-1:0] stop_vec;

  for (genvar k = 0; k < N; k++) begin : g_chan
    assign hit[k]      = tick && (count == match_vals[k]);
    assign flag_set[k] = hit[k] && mctrl[k*MC_BITS + MC_IRQ];
    assign clr_vec[k]  = hit[k] && mctrl[k*MC_BITS + MC_CLR];
    assign stop_vec[k] = hit[k] && mctrl[k*MC_BITS + MC_STOP];
  end

  assign clr_hit  = |clr_vec;
  assign stop_hit = |stop_vec;
endmodule

// File: rtl/mt_flags.sv
module mt_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flags_nx;

  // a new event outranks a clear landing in the same cycle
  assign flags_nx = (flags & ~clr) | set;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_nx;
      irq   <= |flags_nx;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_chk
    // R7: set wins over a coincident clear
    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
      set[k] |=> flags[k]);
    // R6: a one written without a new event clears the flag
    p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
      (clr[k] && !set[k]) |=> !flags[k]);
    // R6: no clear and no set keeps the flag
    p_keep_r6: assert property (@(posedge clk) disable iff (rst)
      (!clr[k] && !set[k]) |=> (flags[k] == $past(flags[k])));
  end

  // R8: the request holds while no set flag is being cleared
  p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (irq && ((flags & clr) == '0)) |=> irq);
endmodule

// File: rtl/match_timer.sv
module match_timer
  import mt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_MATCH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int MC_W = NUM_MATCH * MC_BITS;

  logic                             run_q;
  logic [DATA_W-1:0]                presc_q;
  logic [MC_W-1:0]                  mctrl_q;
  logic [NUM_MATCH-1:0][DATA_W-1:0] match_q;

  logic [DATA_W-1:0]    pcount;
  logic                 tick;
  logic [DATA_W-1:0]    count;
  logic [NUM_MATCH-1:0] flag_set;
  logic                 clr_hit;
  logic                 stop_hit;
  logic [NUM_MATCH-1:0] flags;
  logic [NUM_MATCH-1:0] w1c;
  logic [DATA_W-1:0]    rd_mux;

  logic wr_ctrl, wr_presc, wr_mctrl, wr_flags;
  assign wr_ctrl  = reg_we && (reg_addr == A_CTRL);
  assign wr_presc = reg_we && (reg_addr == A_PRESC);
  assign wr_mctrl = reg_we && (reg_addr == A_MCTRL);
  assign wr_flags = reg_we && (reg_addr == A_FLAGS);
  assign w1c      = wr_flags ? reg_wdata[NUM_MATCH-1:0] : '0;

  // configuration registers
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      presc_q <= '0;
      mctrl_q <= '0;
      match_q <= '0;
    end else begin
      if (stop_hit)     run_q <= 1'b0;
      else if (wr_ctrl) run_q <= reg_wdata[RUN_BIT];
      if (wr_presc) presc_q <= reg_wdata;
      if (wr_mctrl) mctrl_q <= reg_wdata[MC_W-1:0];
      for (int k = 0; k < NUM_MATCH; k++) begin
        if (reg_we && (reg_addr == ADDR_W'(int'(A_MATCH0) + k)))
          match_q[k] <= reg_wdata;
      end
    end
  end

  mt_prescale #(.W(DATA_W)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .run    (run_q),
    .limit  (presc_q),
    .pcount (pcount),
    .tick   (tick)
  );

  mt_match_bank #(.N(NUM_MATCH), .W(DATA_W)) u_bank (
    .tick       (tick),
    .count      (count),
    .match_vals (match_q),
    .mctrl      (mctrl_q),
    .flag_set   (flag_set),
    .clr_hit    (clr_hit),
    .stop_hit   (stop_hit)
  );

  mt_count #(.W(DATA_W)) u_count (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .clr_hit (clr_hit),
    .count   (count)
  );

  mt_flags #(.N(NUM_MATCH)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .set   (flag_set),
    .clr   (w1c),
    .flags (flags),
    .irq   (irq)
  );

  // registered read port
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_CTRL:  rd_mux[RUN_BIT] = run_q;
      A_PRESC: rd_mux = presc_q;
      A_PCNT:  rd_mux = pcount;
      A_COUNT: rd_mux = count;
      A_MCTRL: rd_mux = {{(DATA_W-MC_W){1'b0}}, mctrl_q};
      A_FLAGS: rd_mux = {{(DATA_W-NUM_MATCH){1'b0}}, flags};
      default: begin
        for (int k = 0; k < NUM_MATCH; k++)
          if (reg_addr == ADDR_W'(int'(A_MATCH0) + k)) rd_mux = match_q[k];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  // R9: a stop hit halts the timer on the next cycle, over any write
  p_stop_r9: assert property (@(posedge clk) disable iff (rst)
    stop_hit |=> !run_q);

  // R10: read data follows the address of the previous cycle
  p_read_count_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_COUNT) |=> (reg_rdata == $past(count)));
endmodule

// File: tb/match_timer_tb.sv
module match_timer_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  match_timer #(.DATA_W(32), .NUM_MATCH(4)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq)
  );

  typedef struct packed {
    logic [1:0]  op;    // 0 write, 1 read-check, 2 idle dat cycles, 3 irq check
    logic [3:0]  addr;
    logic [31:0] dat;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 21;
  // prescale 1, channel 0 match 3 with interrupt+reset: one hit per 8 cycles
  localparam vec_t VEC [NV] = '{
    '{2'd0, 4'h1, 32'd1, 32'd0, 4'd2},  // prescale limit 1
    '{2'd0, 4'h8, 32'd3, 32'd0, 4'd3},  // match 0 = 3
    '{2'd0, 4'h4, 32'd3, 32'd0, 4'd3},  // ch0 interrupt + reset
    '{2'd0, 4'h0, 32'd1, 32'd0, 4'd2},  // run (edge E)
    '{2'd1, 4'h3, 32'd0, 32'd0, 4'd2},  // R2 count 0 before first advance
    '{2'd2, 4'h0, 32'd4, 32'd0, 4'd2},
    '{2'd1, 4'h3, 32'd0, 32'd2, 4'd2},  // R2 two advances in four cycles
    '{2'd3, 4'h0, 32'd0, 32'd0, 4'd8},  // R8 low before hit
    '{2'd2, 4'h0, 32'd2, 32'd0, 4'd8},
    '{2'd3, 4'h0, 32'd0, 32'd1, 4'd8},  // R8 high after hit
    '{2'd1, 4'h5, 32'd0, 32'd1, 4'd5},  // R5 flag 0 latched
    '{2'd0, 4'h5, 32'd0, 32'd0, 4'd6},  // write zero
    '{2'd1, 4'h5, 32'd0, 32'd1, 4'd6},  // R6 zero has no effect
    '{2'd0, 4'h5, 32'd1, 32'd0, 4'd6},  // write one
    '{2'd3, 4'h0, 32'd0, 32'd0, 4'd8},  // R8 drops after clear
    '{2'd1, 4'h5, 32'd0, 32'd0, 4'd6},  // R6 cleared
    '{2'd2, 4'h0, 32'd3, 32'd0, 4'd3},
    '{2'd3, 4'h0, 32'd0, 32'd1, 4'd3},  // R3 next hit 8 cycles later
    '{2'd2, 4'h0, 32'd7, 32'd0, 4'd7},
    '{2'd0, 4'h5, 32'd1, 32'd0, 4'd7},  // clear on the hit edge
    '{2'd1, 4'h5, 32'd0, 32'd1, 4'd7}   // R7 set wins
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a;
    @(negedge clk);
    chk(reg_rdata, exp, tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk({31'd0, irq}, 32'd0, "R1 irq");
    rd(4'h0, 32'd0, "R1 ctrl");
    rd(4'h1, 32'd0, "R1 presc");
    rd(4'h4, 32'd0, "R1 mctrl");
    rd(4'h5, 32'd0, "R1 flags");
    rd(4'h8, 32'd0, "R1 match0");
    idle(5);
    rd(4'h3, 32'd0, "R2 halted count");
    rd(4'h2, 32'd0, "R2 halted prescale");

    // vector table
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: wr(VEC[i].addr, VEC[i].dat);
        2'd1: rd(VEC[i].addr, VEC[i].exp, $sformatf("R%0d vec%0d", VEC[i].rq, i));
        2'd2: idle(int'(VEC[i].dat));
        default: chk({31'd0, irq}, VEC[i].exp, $sformatf("R%0d vec%0d irq", VEC[i].rq, i));
      endcase
    end

    // R1 reset in mid-run
    do_reset();
    chk({31'd0, irq}, 32'd0, "R1 irq after run");
    rd(4'h3, 32'd0, "R1 count after run");
    rd(4'h5, 32'd0, "R1 flags after run");

    // R4 no reset: count passes match value
    wr(4'h8, 32'd2);
    wr(4'h4, 32'd1);
    wr(4'h0, 32'd1);
    idle(3);
    rd(4'h3, 32'd3, "R4 count past match");
    idle(4);
    rd(4'h3, 32'd8, "R4 keeps counting");
    chk({31'd0, irq}, 32'd1, "R8 irq from ch0");

    // R9 stop on channel 1 match 4 with interrupt
    do_reset();
    wr(4'hB, 32'h0000ABCD);
    rd(4'hB, 32'h0000ABCD, "R10 match3 readback");
    wr(4'h3, 32'd77);
    rd(4'h3, 32'd0, "R10 count write ignored");
    wr(4'h9, 32'd4);
    wr(4'h4, 32'h28);
    wr(4'h0, 32'd1);
    idle(8);
    rd(4'h3, 32'd5, "R9 count frozen after stop");
    rd(4'h0, 32'd0, "R9 run bit cleared");
    rd(4'h5, 32'd2, "R5 flag 1 latched");
    chk({31'd0, irq}, 32'd1, "R8 irq from ch1");
    wr(4'h5, 32'd2);
    chk({31'd0, irq}, 32'd0, "R6 irq after clearing ch1");

    // R3 wrap with interrupt disabled: R5 no flag
    do_reset();
    wr(4'h8, 32'd1);
    wr(4'h4, 32'd2);
    wr(4'h0, 32'd1);
    idle(10);
    rd(4'h3, 32'd0, "R3 period two wrap");
    rd(4'h5, 32'd0, "R5 no flag without interrupt bit");
    chk({31'd0, irq}, 32'd0, "R8 irq stays low");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule